// File: doc/BRIEF.md
# Master/slave audio clock divider

This block builds the audio system clocks from one high-frequency clock that an external PLL supplies. In master mode it divides that clock into a master clock output, a bit clock at 64 times the sample rate and a frame clock at the sample rate. All of them are registered levels in the high-frequency domain, and beside them it gives single-cycle strobes that announce each coming bit-clock edge and each frame-clock edge. Downstream logic can then act on those edges as clock enables, with no second clock domain.

The high-frequency input is a fixed multiple of the sample rate, and that multiple halves each time the speed doubles: 2048 Fs at normal speed (44.1/48 kHz), 1024 Fs at double speed (88.2/96 kHz) and 512 Fs at quad speed (176.4/192 kHz). The bit-clock, frame-clock and master-clock divisors therefore change with the speed selection. The master clock is 256 Fs at normal and double speed and 128 Fs at quad speed.

In slave mode another device supplies the bit and frame clocks. The block then holds the master clock output low, holds the bit and frame levels and strobes low, and clears the two output-enable flags so that the pads can turn into inputs. A speed change, a period in slave mode or a reset clears every divider, so the clocks always restart from a known phase.

Top module: `audio_clkgen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, mclk_out, bclk_out and lrclk_out are 0 and no strobe is asserted.
- R2: In master mode, mclk_out is a 50% square wave whose half period, counted in clk_hf cycles, is 4 at normal speed and 2 at double and quad speed. This gives divisors of 8, 4 and 4, which are 256 Fs, 256 Fs and 128 Fs. The speed_sel encoding is 0 = normal, 1 = double, 2 = quad.
- R3: In master mode, bclk_out is a 50% square wave with a divisor of 32, 16 or 8 (normal, double, quad). bclk_rise or bclk_fall is high in exactly the cycle before bclk_out goes high or goes low.
- R4: In master mode, lrclk_out is a 50% square wave with a divisor of 2048, 1024 or 512. It changes only in the cycle after a bclk_fall strobe, once every 32 bit-clock periods. lrclk_edge is high in the cycle before each change.
- R5: With master_sel = 0 (slave), mclk_out, bclk_out, lrclk_out, all strobes, bclk_oe and lrclk_oe are 0. With master_sel = 1, bclk_oe and lrclk_oe are 1.
- R6: Phase is counted as k, the number of clk_hf edges since the last edge that sampled rst_n low, master_sel low, or speed_sel different from the value taken at the edge before. Each output level is floor(k / half) mod 2, where half is that output's half period. A speed change in the middle of a frame therefore restarts every clock from 0.
- R7: speed_sel = 3 produces the same divisors as quad speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hf | input | 1 | High-frequency clock from the external PLL |
| rst_n | input | 1 | Active-low reset, synchronous to clk_hf |
| master_sel | input | 1 | 1 = master (block drives clocks), 0 = slave |
| speed_sel | input | 2 | 0 normal, 1 double, 2 or 3 quad |
| mclk_out | output | 1 | Master clock output level (0 in slave mode) |
| bclk_out | output | 1 | Bit clock level, 64 Fs |
| bclk_rise | output | 1 | Strobe: bclk_out goes high at the next edge |
| bclk_fall | output | 1 | Strobe: bclk_out goes low at the next edge |
| bclk_oe | output | 1 | Bit clock pad drive enable |
| lrclk_out | output | 1 | Frame clock level, Fs |
| lrclk_edge | output | 1 | Strobe: lrclk_out toggles at the next edge |
| lrclk_oe | output | 1 | Frame clock pad drive enable |

## Verification
The bench builds the block with its defaults: 2048 high-frequency cycles per sample at normal speed, 64 bit slots per frame, and master-clock ratios of 256 and 128. Every clock level and strobe is compared in every cycle against a phase counter kept by the bench. It runs two full frames at each of the four speed codes, so every divisor, every wrap of the frame counter and the quad alias fall within the sweep. A speed switch part-way through a frame, a slave interval and a return to master test the restart rule from a phase that is not zero.

// File: rtl/acg_pkg.sv
package acg_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_QUAD2  = 2'd3
  } speed_e;

  // Octave shift of the high-frequency multiple for a speed code.
  function automatic int unsigned speed_shift(logic [1:0] s);
    return (s == SPD_NORMAL) ? 0 : (s == SPD_DOUBLE) ? 1 : 2;
  endfunction

  function automatic bit is_quad(logic [1:0] s);
    return s[1];
  endfunction

  // High-frequency cycles per sample at a given speed.
  function automatic int unsigned hf_per_fs(int unsigned base, logic [1:0] s);
    return base >> speed_shift(s);
  endfunction

  // Half period of the bit clock in high-frequency cycles.
  function automatic int unsigned bclk_half(int unsigned base, int unsigned slots,
                                            logic [1:0] s);
    return hf_per_fs(base, s) / (slots * 2);
  endfunction

  // Half period of the master clock in high-frequency cycles.
  function automatic int unsigned mclk_half(int unsigned base, int unsigned fs_hi,
                                            int unsigned fs_q, logic [1:0] s);
    return is_quad(s) ? hf_per_fs(base, s) / (fs_q * 2)
                      : hf_per_fs(base, s) / (fs_hi * 2);
  endfunction

endpackage

// File: rtl/acg_speed_ctl.sv
module acg_speed_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_sel,
  input  logic [1:0] speed_sel,
  output logic [1:0] speed_q,
  output logic       restart
);
  import acg_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) speed_q <= SPD_NORMAL;
    else        speed_q <= speed_sel;
  end

  // Any cycle in slave mode, or the cycle a new speed is seen, zeroes the dividers.
  assign restart = !master_sel || (speed_sel != speed_q);

endmodule

// File: rtl/acg_div.sv
module acg_div #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] half,
  output logic          lvl,
  output logic          rise_stb,
  output logic          fall_stb
);
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == half - CW'(1)) && !restart;
  assign rise_stb = wrap && !lvl;
  assign fall_stb = wrap && lvl;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      lvl <= !lvl;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/acg_frame.sv
module acg_frame #(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [FW-1:0] half_bits,
  output logic          lvl,
  output logic          edge_stb
);
  logic [FW-1:0] fcnt;

  assign edge_stb = step && !restart && (fcnt == half_bits - FW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      fcnt <= '0;
      lvl  <= 1'b0;
    end else if (edge_stb) begin
      fcnt <= '0;
      lvl  <= !lvl;
    end else if (step) begin
      fcnt <= fcnt + FW'(1);
    end
  end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int unsigned HF_PER_FS = 2048,
  parameter int unsigned SLOTS     = 64,
  parameter int unsigned MCLK_FS   = 256,
  parameter int unsigned MCLK_FS_Q = 128
) (
  input  logic       clk_hf,
  input  logic       rst_n,
  input  logic       master_sel,
  input  logic [1:0] speed_sel,
  output logic       mclk_out,
  output logic       bclk_out,
  output logic       bclk_rise,
  output logic       bclk_fall,
  output logic       bclk_oe,
  output logic       lrclk_out,
  output logic       lrclk_edge,
  output logic       lrclk_oe
);
  import acg_pkg::*;

  localparam int CW = $clog2(HF_PER_FS) + 1;
  localparam int FW = $clog2(SLOTS) + 1;
  localparam int NDIV = 2;
  localparam int IDX_MCLK = 0;
  localparam int IDX_BCLK = 1;

  logic [1:0]    speed_q;
  logic          restart;
  logic [CW-1:0] half_tbl [NDIV];
  logic [NDIV-1:0] div_lvl, div_rise, div_fall;
  logic          lr_lvl, lr_edge;
  logic          bclk_fall_evt;

  acg_speed_ctl u_spd (
    .clk        (clk_hf),
    .rst_n      (rst_n),
    .master_sel (master_sel),
    .speed_sel  (speed_sel),
    .speed_q    (speed_q),
    .restart    (restart)
  );

  always_comb begin
    half_tbl[IDX_MCLK] = CW'(mclk_half(HF_PER_FS, MCLK_FS, MCLK_FS_Q, speed_q));
    half_tbl[IDX_BCLK] = CW'(bclk_half(HF_PER_FS, SLOTS, speed_q));
  end

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    acg_div #(.CW(CW)) u_div (
      .clk      (clk_hf),
      .rst_n    (rst_n),
      .restart  (restart),
      .half     (half_tbl[g]),
      .lvl      (div_lvl[g]),
      .rise_stb (div_rise[g]),
      .fall_stb (div_fall[g])
    );
  end

  assign bclk_fall_evt = div_fall[IDX_BCLK];

  acg_frame #(.FW(FW)) u_frame (
    .clk       (clk_hf),
    .rst_n     (rst_n),
    .restart   (restart),
    .step      (bclk_fall_evt),
    .half_bits (FW'(SLOTS / 2)),
    .lvl       (lr_lvl),
    .edge_stb  (lr_edge)
  );

  assign mclk_out   = master_sel && div_lvl[IDX_MCLK];
  assign bclk_out   = master_sel && div_lvl[IDX_BCLK];
  assign bclk_rise  = master_sel && div_rise[IDX_BCLK];
  assign bclk_fall  = master_sel && div_fall[IDX_BCLK];
  assign lrclk_out  = master_sel && lr_lvl;
  assign lrclk_edge = master_sel && lr_edge;
  assign bclk_oe    = master_sel;
  assign lrclk_oe   = master_sel;

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic master_sel,
  input logic restart,
  input logic mclk_out,
  input logic bclk_out,
  input logic bclk_rise,
  input logic bclk_fall,
  input logic bclk_oe,
  input logic lrclk_out,
  input logic lrclk_edge,
  input logic lrclk_oe
);

  // R3: strobes never coincide
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bclk_rise && bclk_fall));

  // R3: a rise strobe is followed by a high bit clock
  a_r3_rise_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |=> (bclk_out || !master_sel));

  // R3: a fall strobe is followed by a low bit clock
  a_r3_fall_then_low: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall |=> !bclk_out);

  // R4: frame clock moves only after a bit-clock fall strobe
  a_r4_lr_on_bfall: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && $past(master_sel) && !$past(restart) && (lrclk_out != $past(lrclk_out)))
    |-> $past(bclk_fall));

  // R4: a frame strobe is followed by a frame clock change
  a_r4_edge_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (lrclk_edge && master_sel) |=> (lrclk_out != $past(lrclk_out) || !master_sel));

  // R5: slave mode keeps every driven output quiet
  a_r5_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> (!mclk_out && !bclk_oe && !lrclk_oe && !bclk_rise && !lrclk_edge));

  // R6: a restart leaves all levels low
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!mclk_out && !bclk_out && !lrclk_out));

endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk        (clk_hf),
  .rst_n      (rst_n),
  .master_sel (master_sel),
  .restart    (restart),
  .mclk_out   (mclk_out),
  .bclk_out   (bclk_out),
  .bclk_rise  (bclk_rise),
  .bclk_fall  (bclk_fall),
  .bclk_oe    (bclk_oe),
  .lrclk_out  (lrclk_out),
  .lrclk_edge (lrclk_edge),
  .lrclk_oe   (lrclk_oe)
);

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk_hf = 1'b0;
  logic       rst_n  = 1'b0;
  logic       master_sel = 1'b1;
  logic [1:0] speed_sel  = 2'd0;
  logic mclk_out, bclk_out, bclk_rise, bclk_fall, bclk_oe;
  logic lrclk_out, lrclk_edge, lrclk_oe;

  int checks = 0;
  int failures = 0;
  int k = 0;
  logic [1:0] prev_spd = 2'd0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_hf = ~clk_hf;

  audio_clkgen u_dut (
    .clk_hf(clk_hf), .rst_n(rst_n), .master_sel(master_sel), .speed_sel(speed_sel),
    .mclk_out(mclk_out), .bclk_out(bclk_out), .bclk_rise(bclk_rise),
    .bclk_fall(bclk_fall), .bclk_oe(bclk_oe), .lrclk_out(lrclk_out),
    .lrclk_edge(lrclk_edge), .lrclk_oe(lrclk_oe)
  );

  // Phase model per R6.
  always @(posedge clk_hf) begin
    if (!rst_n || !master_sel || speed_sel != prev_spd) k <= 0;
    else k <= k + 1;
    prev_spd <= rst_n ? speed_sel : 2'd0;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s k=%0d spd=%0d actual=%0d expected=%0d",
               req, what, k, speed_sel, act, exp);
    end
  endtask

  // Half periods from the requirements, written as sample-rate arithmetic.
  function automatic int hf_mult(logic [1:0] s);
    return (s == 0) ? 2048 : (s == 1) ? 1024 : 512;
  endfunction
  function automatic int lvl_at(int kk, int h);
    return (kk / h) % 2;
  endfunction

  task automatic check_cycle(string tagm, string tagb, string tagl);
    int hm, hb, hl, m;
    hm = (speed_sel >= 2) ? hf_mult(speed_sel) / 256 : hf_mult(speed_sel) / 512;
    hb = hf_mult(speed_sel) / 128;
    hl = hf_mult(speed_sel) / 2;
    m  = master_sel ? 1 : 0;
    chk(tagm, "mclk_out", mclk_out, m * lvl_at(k, hm));
    chk(tagb, "bclk_out", bclk_out, m * lvl_at(k, hb));
    chk(tagb, "bclk_rise", bclk_rise,
        m * ((lvl_at(k, hb) == 0 && lvl_at(k+1, hb) == 1) ? 1 : 0));
    chk(tagb, "bclk_fall", bclk_fall,
        m * ((lvl_at(k, hb) == 1 && lvl_at(k+1, hb) == 0) ? 1 : 0));
    chk(tagl, "lrclk_out", lrclk_out, m * lvl_at(k, hl));
    chk(tagl, "lrclk_edge", lrclk_edge,
        m * ((lvl_at(k, hl) != lvl_at(k+1, hl)) ? 1 : 0));
    chk("R5", "bclk_oe", bclk_oe, m);
    chk("R5", "lrclk_oe", lrclk_oe, m);
  endtask

  task automatic run(int n, string tagm, string tagb, string tagl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_hf);
      check_cycle(tagm, tagb, tagl);
    end
  endtask

  always @(posedge clk_hf) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (5) begin
      @(negedge clk_hf);
      chk("R1", "mclk_out in reset", mclk_out, 0);
      chk("R1", "bclk_out in reset", bclk_out, 0);
      chk("R1", "lrclk_out in reset", lrclk_out, 0);
      chk("R1", "strobes in reset", bclk_rise | bclk_fall | lrclk_edge, 0);
    end
    rst_n = 1'b1;
    @(negedge clk_hf);
    chk("R1", "bclk_out after reset", bclk_out, 0);
    chk("R1", "lrclk_out after reset", lrclk_out, 0);
    check_cycle("R2", "R3", "R4");
    // Normal speed, two frames
    run(4100, "R2", "R3", "R4");
    // Double speed
    speed_sel = 2'd1;
    run(2100, "R2", "R3", "R4");
    // Quad speed
    speed_sel = 2'd2;
    run(1100, "R2", "R3", "R4");
    // R7: code 3 aliases quad
    speed_sel = 2'd3;
    run(1100, "R7", "R7", "R7");
    // R6: mid-frame change from normal to double
    speed_sel = 2'd0;
    run(1500, "R6", "R6", "R6");
    speed_sel = 2'd1;
    run(1200, "R6", "R6", "R6");
    // R5: slave interval
    master_sel = 1'b0;
    run(300, "R5", "R5", "R5");
    // R6: return to master restarts from zero
    master_sel = 1'b1;
    run(2100, "R6", "R6", "R6");
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule